// File: doc/BRIEF.md
# Page Translation Lookaside Cache

This block sits in front of a two-level page-table walker and keeps the most recent virtual-page to physical-frame translations. A lookup presents a 20-bit virtual page number and a write flag. One cycle later the block answers with a hit flag, the cached frame number and the cached permission bits. The walker is started only when the answer is a miss. When the walk completes, the walker loads its result through the fill port.

The cache holds eight entries. It is fully associative and replaces entries in round-robin order. Each entry stores the tag, the frame number, two permission bits and a flag that records whether the dirty bit in memory is already set. The cache does not follow stores to the page tables in memory. Stale entries leave only through a whole-cache flush. A flush happens on every move into the directory base register. It also happens on a task switch that loads a base value different from the one held.

A write lookup that finds an entry whose dirty flag is still clear is answered as a miss. The walker then runs and sets the dirty bit in the table.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid, `rsp_valid` is 0, and any lookup misses.
- R2: Every cycle with `lkp_valid` high produces exactly one response, with `rsp_valid` high, in the following cycle. Without a lookup, `rsp_valid` is 0 in the following cycle.
- R3: A read lookup of a cached page answers with `rsp_hit`=1, the stored frame number and the stored permission bits. Bit 1 of the permission field is the write-enable bit and bit 0 is the user bit, passed through unchanged.
- R4: A write lookup (`lkp_write`=1) that matches an entry filled with `fill_dirty`=0 answers as a miss. If the matching entry was filled with `fill_dirty`=1, the write lookup hits.
- R5: A fill with `fill_present`=0 is not cached, and later lookups of that page miss.
- R6: A cycle with `base_mov` high invalidates every entry. From the next cycle on, all lookups miss until new fills arrive.
- R7: A `base_task` load whose `base_new` differs from the held base value invalidates every entry. A load of the same value leaves the entries intact. Both kinds of load update the held base value.
- R8: A lookup issued in the same cycle as a flush misses.
- R9: A fill issued in the same cycle as a flush is discarded.
- R10: After reset or a flush, fills of new pages occupy the slots in order. The ninth new-page fill evicts the page that was filled first, and leaves the others in place.
- R11: A fill of a page that is already cached overwrites that entry in place. It does not take a new slot, and the replacement order does not advance.
- R12: A lookup issued in the same cycle as a fill sees the contents from before that fill.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_vpn | input | 20 | Virtual page number to translate |
| lkp_write | input | 1 | Lookup is for a write access |
| fill_valid | input | 1 | Walk result present this cycle |
| fill_present | input | 1 | Present bit was 1 at both table levels |
| fill_vpn | input | 20 | Virtual page number of the walk result |
| fill_pfn | input | 20 | Physical frame number of the walk result |
| fill_perm | input | 2 | Combined permissions: bit 1 write-enable, bit 0 user |
| fill_dirty | input | 1 | Dirty bit in memory is already set |
| base_mov | input | 1 | Move into the directory base register |
| base_task | input | 1 | Task switch loads the directory base register |
| base_new | input | 20 | Base value carried by a move or task switch |
| rsp_valid | output | 1 | Response to the lookup of the previous cycle |
| rsp_hit | output | 1 | Translation found and usable |
| rsp_pfn | output | 20 | Frame number on a hit, zero otherwise |
| rsp_perm | output | 2 | Permission bits on a hit, zero otherwise |

## Verification
Every response is due one clock edge after the lookup that caused it. Flushes, fills and base loads change the cache at that same edge, so they affect only lookups issued in later cycles. The driver sets each stimulus just after a falling edge and queues the expected answer in the same cycle. The monitor compares the registered response at the next falling edge, one rising edge later, and pops one item for each `rsp_valid`. Cycles that combine a lookup with a flush or a fill are driven as one cycle, which pins the same-edge ordering of R8, R9 and R12.

// File: rtl/xlat_cache_pkg.sv
`timescale 1ns/1ps
package xlat_cache_pkg;

    localparam int VPN_W  = 20;
    localparam int PFN_W  = 20;
    localparam int PERM_W = 2;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
        logic              dirty;
    } xc_entry_t;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [PFN_W-1:0]  pfn;
        logic [PERM_W-1:0] perm;
    } xc_rsp_t;

endpackage

// File: rtl/xlat_match.sv
`timescale 1ns/1ps
// Parallel tag compare across all entries, with one-hot to index encoding.
module xlat_match
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  xc_entry_t [ENTRIES-1:0] ents,
    input  logic [VPN_W-1:0]        vpn,
    output logic [ENTRIES-1:0]      hit_vec,
    output logic                    any,
    output logic [IDX_W-1:0]        idx
);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_vec[g] = ents[g].valid && (ents[g].vpn == vpn);
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (hit_vec[i]) begin
                idx = idx | IDX_W'(i);
            end
        end
    end

    assign any = |hit_vec;

endmodule

// File: rtl/xlat_flush_ctl.sv
`timescale 1ns/1ps
// Holds the directory base value and decides when the cache must be emptied.
module xlat_flush_ctl #(
    parameter int BASE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_mov,
    input  logic              base_task,
    input  logic [BASE_W-1:0] base_new,
    output logic              flush
);

    logic [BASE_W-1:0] base_d, base_q;

    always_comb begin
        base_d = base_q;
        flush  = base_mov || (base_task && (base_new != base_q));
        if (base_mov || base_task) begin
            base_d = base_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
        end else begin
            base_q <= base_d;
        end
    end

endmodule

// File: rtl/xlat_cache.sv
`timescale 1ns/1ps
module xlat_cache
    import xlat_cache_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int BASE_W  = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lkp_valid,
    input  logic [VPN_W-1:0]  lkp_vpn,
    input  logic              lkp_write,
    input  logic              fill_valid,
    input  logic              fill_present,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [PERM_W-1:0] fill_perm,
    input  logic              fill_dirty,
    input  logic              base_mov,
    input  logic              base_task,
    input  logic [BASE_W-1:0] base_new,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [PFN_W-1:0]  rsp_pfn,
    output logic [PERM_W-1:0] rsp_perm
);

    typedef struct packed {
        xc_entry_t [ENTRIES-1:0] ents;
        logic [IDX_W-1:0]        ptr;
        xc_rsp_t                 rsp;
    } state_t;

    state_t st_d, st_q;

    logic                flush;
    logic [ENTRIES-1:0]  lk_hit_vec;
    logic                lk_any;
    logic [IDX_W-1:0]    lk_idx;
    logic [ENTRIES-1:0]  fl_hit_vec;
    logic                fl_any;
    logic [IDX_W-1:0]    fl_idx;
    logic [ENTRIES-1:0]  valid_vec;

    xlat_flush_ctl #(.BASE_W(BASE_W)) u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_mov  (base_mov),
        .base_task (base_task),
        .base_new  (base_new),
        .flush     (flush)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_lk_match (
        .ents    (st_q.ents),
        .vpn     (lkp_vpn),
        .hit_vec (lk_hit_vec),
        .any     (lk_any),
        .idx     (lk_idx)
    );

    xlat_match #(.ENTRIES(ENTRIES)) u_fl_match (
        .ents    (st_q.ents),
        .vpn     (fill_vpn),
        .hit_vec (fl_hit_vec),
        .any     (fl_any),
        .idx     (fl_idx)
    );

    for (genvar g = 0; g < ENTRIES; g++) begin : g_valid
        assign valid_vec[g] = st_q.ents[g].valid;
    end

    always_comb begin
        logic             usable;
        logic [IDX_W-1:0] slot;
        st_d = st_q;

        // Response path: sees contents from before this cycle's updates.
        usable = lkp_valid && lk_any && !flush
                 && (!lkp_write || st_q.ents[lk_idx].dirty);
        st_d.rsp.valid = lkp_valid;
        st_d.rsp.hit   = usable;
        st_d.rsp.pfn   = usable ? st_q.ents[lk_idx].pfn  : '0;
        st_d.rsp.perm  = usable ? st_q.ents[lk_idx].perm : '0;

        // Update path: a flush wins over any fill in the same cycle.
        slot = fl_any ? fl_idx : st_q.ptr;
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                st_d.ents[i].valid = 1'b0;
            end
            st_d.ptr = '0;
        end else if (fill_valid && fill_present) begin
            st_d.ents[slot].valid = 1'b1;
            st_d.ents[slot].vpn   = fill_vpn;
            st_d.ents[slot].pfn   = fill_pfn;
            st_d.ents[slot].perm  = fill_perm;
            st_d.ents[slot].dirty = fill_dirty;
            if (!fl_any) begin
                st_d.ptr = (st_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : st_q.ptr + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp.valid;
    assign rsp_hit   = st_q.rsp.hit;
    assign rsp_pfn   = st_q.rsp.pfn;
    assign rsp_perm  = st_q.rsp.perm;

endmodule

// File: rtl/xlat_cache_chk.sv
`timescale 1ns/1ps
module xlat_cache_chk #(
    parameter int ENTRIES = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lkp_valid,
    input logic               fill_valid,
    input logic               fill_present,
    input logic               base_mov,
    input logic               base_task,
    input logic               rsp_valid,
    input logic               rsp_hit,
    input logic [ENTRIES-1:0] valid_vec,
    input logic [ENTRIES-1:0] lk_hit_vec
);

    p_rsp_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_valid |=> rsp_valid);

    p_rsp_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !lkp_valid |=> !rsp_valid);

    p_hit_in_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> rsp_valid);

    p_mov_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
        base_mov |=> (valid_vec == '0));

    p_flush_lookup_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_valid && base_mov) |=> !rsp_hit);

    p_absent_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_valid && !fill_present && !base_mov && !base_task) |=> $stable(valid_vec));

    p_unique_tag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_hit_vec));

endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .lkp_valid    (lkp_valid),
    .fill_valid   (fill_valid),
    .fill_present (fill_present),
    .base_mov     (base_mov),
    .base_task    (base_task),
    .rsp_valid    (rsp_valid),
    .rsp_hit      (rsp_hit),
    .valid_vec    (valid_vec),
    .lk_hit_vec   (lk_hit_vec)
);

// File: tb/xlat_cache_test.sv
`timescale 1ns/1ps
module xlat_cache_test;

    typedef struct packed {
        logic        hit;
        logic [19:0] pfn;
        logic [1:0]  perm;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lkp_valid = 1'b0;
    logic [19:0] lkp_vpn = '0;
    logic        lkp_write = 1'b0;
    logic        fill_valid = 1'b0;
    logic        fill_present = 1'b0;
    logic [19:0] fill_vpn = '0;
    logic [19:0] fill_pfn = '0;
    logic [1:0]  fill_perm = '0;
    logic        fill_dirty = 1'b0;
    logic        base_mov = 1'b0;
    logic        base_task = 1'b0;
    logic [19:0] base_new = '0;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [19:0] rsp_pfn;
    logic [1:0]  rsp_perm;

    int checks = 0;
    int errors = 0;
    exp_t  exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    xlat_cache uut (
        .clk(clk), .rst_n(rst_n),
        .lkp_valid(lkp_valid), .lkp_vpn(lkp_vpn), .lkp_write(lkp_write),
        .fill_valid(fill_valid), .fill_present(fill_present), .fill_vpn(fill_vpn),
        .fill_pfn(fill_pfn), .fill_perm(fill_perm), .fill_dirty(fill_dirty),
        .base_mov(base_mov), .base_task(base_task), .base_new(base_new),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm)
    );

    // Driver helpers: set inputs just after a falling edge; cycle() ends the cycle.
    task automatic set_lkp(input logic [19:0] vpn, input logic wr, input logic eh,
                           input logic [19:0] epfn, input logic [1:0] eperm, input string tag);
        exp_t e;
        lkp_valid = 1'b1; lkp_vpn = vpn; lkp_write = wr;
        e.hit = eh; e.pfn = epfn; e.perm = eperm;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    task automatic set_fill(input logic [19:0] vpn, input logic [19:0] pfn,
                            input logic [1:0] perm, input logic dirty, input logic pres);
        fill_valid = 1'b1; fill_vpn = vpn; fill_pfn = pfn;
        fill_perm = perm; fill_dirty = dirty; fill_present = pres;
    endtask

    task automatic cycle();
        @(negedge clk);
        lkp_valid = 1'b0; lkp_write = 1'b0; fill_valid = 1'b0;
        base_mov = 1'b0; base_task = 1'b0;
    endtask

    task automatic look(input logic [19:0] vpn, input logic wr, input logic eh,
                        input logic [19:0] epfn, input logic [1:0] eperm, input string tag);
        set_lkp(vpn, wr, eh, epfn, eperm, tag);
        cycle();
    endtask

    task automatic fill(input logic [19:0] vpn, input logic [19:0] pfn,
                        input logic [1:0] perm, input logic dirty);
        set_fill(vpn, pfn, perm, dirty, 1'b1);
        cycle();
    endtask

    task automatic mov(input logic [19:0] b);
        base_mov = 1'b1; base_new = b;
        cycle();
    endtask

    // Monitor: pops one expected item per response.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected response hit=%0b, expected none", rsp_hit);
            end else begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rsp_hit !== e.hit || (e.hit && (rsp_pfn !== e.pfn || rsp_perm !== e.perm))) begin
                    errors++;
                    $display("FAIL %s: hit=%0b pfn=%h perm=%b, expected hit=%0b pfn=%h perm=%b",
                             t, rsp_hit, rsp_pfn, rsp_perm, e.hit, e.pfn, e.perm);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        checks++;
        if (rsp_valid !== 1'b0 || rsp_hit !== 1'b0) begin
            errors++;
            $display("FAIL R1: rsp_valid=%0b rsp_hit=%0b, expected 0 0", rsp_valid, rsp_hit);
        end
        look(20'h12345, 1'b0, 1'b0, '0, '0, "R1 empty after reset");

        // R3 / R2: basic fill and read hit
        fill(20'h00010, 20'hAAAAA, 2'b11, 1'b0);
        look(20'h00010, 1'b0, 1'b1, 20'hAAAAA, 2'b11, "R3 read hit");
        // R4: write with clean entry misses, dirty entry hits
        look(20'h00010, 1'b1, 1'b0, '0, '0, "R4 write to clean entry");
        fill(20'h00010, 20'hAAAAA, 2'b10, 1'b1);
        look(20'h00010, 1'b1, 1'b1, 20'hAAAAA, 2'b10, "R4 write to dirty entry");
        // R5: not-present fill is dropped
        set_fill(20'h00020, 20'hBBBBB, 2'b01, 1'b1, 1'b0);
        cycle();
        look(20'h00020, 1'b0, 1'b0, '0, '0, "R5 absent fill");
        // R12: lookup with fill in the same cycle sees old contents
        set_fill(20'h00030, 20'hCCCCC, 2'b01, 1'b0, 1'b1);
        set_lkp(20'h00030, 1'b0, 1'b0, '0, '0, "R12 same-cycle fill");
        cycle();
        look(20'h00030, 1'b0, 1'b1, 20'hCCCCC, 2'b01, "R12 after fill");
        // R6: move to base register flushes everything
        mov(20'h00005);
        look(20'h00010, 1'b0, 1'b0, '0, '0, "R6 flushed A");
        look(20'h00030, 1'b0, 1'b0, '0, '0, "R6 flushed C");
        // R7: task switch same base keeps, different base flushes
        fill(20'h00010, 20'h11111, 2'b00, 1'b0);
        base_task = 1'b1; base_new = 20'h00005; cycle();
        look(20'h00010, 1'b0, 1'b1, 20'h11111, 2'b00, "R7 same base kept");
        base_task = 1'b1; base_new = 20'h00006; cycle();
        look(20'h00010, 1'b0, 1'b0, '0, '0, "R7 new base flushed");
        // R8: lookup in the flush cycle misses
        fill(20'h00010, 20'h22222, 2'b11, 1'b1);
        look(20'h00010, 1'b0, 1'b1, 20'h22222, 2'b11, "R8 present before flush");
        base_mov = 1'b1; base_new = 20'h00007;
        set_lkp(20'h00010, 1'b0, 1'b0, '0, '0, "R8 lookup in flush cycle");
        cycle();
        // R9: fill in the flush cycle is discarded
        base_mov = 1'b1; base_new = 20'h00008;
        set_fill(20'h00040, 20'hDDDDD, 2'b11, 1'b1, 1'b1);
        cycle();
        look(20'h00040, 1'b0, 1'b0, '0, '0, "R9 fill in flush cycle");

        // R10: round-robin after a flush
        mov(20'h00009);
        for (int k = 0; k < 8; k++) fill(20'h40000 + 20'(k), 20'h50000 + 20'(k), 2'b01, 1'b1);
        for (int k = 0; k < 8; k++)
            look(20'h40000 + 20'(k), 1'b0, 1'b1, 20'h50000 + 20'(k), 2'b01, "R10 all eight held");
        fill(20'h40008, 20'h50008, 2'b10, 1'b1);
        look(20'h40000, 1'b0, 1'b0, '0, '0, "R10 oldest evicted");
        look(20'h40008, 1'b0, 1'b1, 20'h50008, 2'b10, "R10 newest present");
        look(20'h40001, 1'b0, 1'b1, 20'h50001, 2'b01, "R10 next oldest kept");
        // R11: refill in place, no eviction
        fill(20'h40002, 20'h6AAAA, 2'b11, 1'b1);
        look(20'h40002, 1'b0, 1'b1, 20'h6AAAA, 2'b11, "R11 updated in place");
        for (int k = 1; k < 8; k++) begin
            if (k != 2) look(20'h40000 + 20'(k), 1'b0, 1'b1, 20'h50000 + 20'(k), 2'b01, "R11 others kept");
        end
        look(20'h40008, 1'b0, 1'b1, 20'h50008, 2'b10, "R11 newest kept");

        cycle();
        cycle();
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule